// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Controller

This controller moves words from one peripheral into consecutive memory locations so the processor does not have to copy them itself. Software, through a small write-only configuration port, sets a first memory address, a word count and a bus-sharing policy, then writes the start bit. From then on the controller waits for the peripheral's request, asks the processor for the system bus, and once the bus is granted acknowledges the peripheral and drives one write strobe per word.

Three bus-sharing policies are offered. Burst keeps the bus from the first word to the last. Cycle stealing takes the bus for a single word each time the peripheral reports a word ready, then hands it back. Interleaving only asks for the bus while the processor reports that it is not using it, and returns the bus as soon as the processor wants it again. A one-cycle `done` pulse marks the end of every transfer.

Top module: `dma_single_chan`

## Requirements
- R1: The bus request `hold` rises only in a cycle where the armed controller sees `per_req` high, and `per_ack` is high only while both `hold` and `hlda` are high.
- R2: The k-th word of a transfer (k counting from 0) is written at address start+k, modulo 2^W, and `mem_data` equals `per_data` in the strobe cycle.
- R3: A transfer of N words produces exactly N write strobes, and `done` appears only after the N-th one.
- R4: Once raised, `hold` stays high until `hlda` is seen; `mem_we` is never high unless `hold` and `hlda` are both high.
- R5: Mode 2'b00 (burst), and the unused code 2'b11 which acts the same, writes one word in every granted cycle and keeps `hold` high from the first word to the last, whatever `cpu_busy` does.
- R6: Mode 2'b01 (cycle stealing) drops `hold` in the cycle after each word, so every bus tenure carries a single word, and the next tenure waits for `per_req`.
- R7: Mode 2'b10 (interleaving) raises `hold` only in a cycle where `cpu_busy` is low.
- R8: In interleaving mode, if `cpu_busy` is high when a word is strobed, that word completes and `hold` is low in the next cycle.
- R9: `done` is high for exactly one cycle; in that cycle `hold` and `per_ack` are low and the controller is idle again.
- R10: Writing the start bit with a count of zero raises `done` in the next cycle and never raises `hold`.
- R11: Configuration writes (select 0 = start address, 1 = word count, 2 = mode in bits 1:0, 3 = control with start in bit 0) take effect only while idle; any write after start and before `done` changes neither the addresses, the number of words nor the policy of the running transfer.
- R12: During reset `hold`, `per_ack`, `mem_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_data | input | W | Configuration write data |
| per_req | input | 1 | Peripheral has a word ready |
| per_data | input | DW | Word offered by the peripheral |
| per_ack | output | 1 | Word taken from the peripheral this cycle |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| cpu_busy | input | 1 | Processor is using the bus |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | W | Memory write address |
| mem_data | output | DW | Memory write data |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Each policy is driven with a grant latency of zero to three cycles, random peripheral data, a random processor-busy line and, for cycle stealing, a random ready line; burst runs with a toggling busy line tell a correct burst apart from one that wrongly yields, while interleaving runs separate a correct release on busy from one that keeps the bus. Directed runs cover a start address that wraps past the top of the address space, a zero count, and a storm of configuration writes issued between start and the first grant, which exposes any register that is not frozen while active. Randomly chosen addresses, counts and all four mode codes then check the address sequence, the word count and the single `done` pulse against a bench model.

// File: rtl/dma_single_chan.sv
module dma_single_chan #(
  parameter int W  = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [W-1:0]  cfg_data,
  input  logic          per_req,
  input  logic [DW-1:0] per_data,
  output logic          per_ack,
  output logic          hold,
  input  logic          hlda,
  input  logic          cpu_busy,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          done
);

  localparam logic [1:0] M_BURST = 2'b00;
  localparam logic [1:0] M_STEAL = 2'b01;
  localparam logic [1:0] M_ILV   = 2'b10;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_HOLD, S_XFER} st_t;

  st_t         st, st_nxt;
  logic [W-1:0] addr_r, cnt_r;
  logic [1:0]  mode_r;
  logic        done_r;

  wire idle    = (st == S_IDLE);
  wire cfg_ok  = cfg_wr && idle;
  wire go      = cfg_ok && (cfg_sel == SEL_CTRL) && cfg_data[0];
  wire steal   = (mode_r == M_STEAL);
  wire ilv     = (mode_r == M_ILV);
  wire last    = (cnt_r == W'(1));

  assign hold     = (st == S_HOLD) || (st == S_XFER);
  assign mem_we   = (st == S_XFER) && hlda;
  assign per_ack  = mem_we;
  assign mem_addr = addr_r;
  assign mem_data = per_data;
  assign done     = done_r;

  always_comb begin
    st_nxt = st;
    case (st)
      S_IDLE:  if (go && cnt_r != '0) st_nxt = S_ARMED;
      S_ARMED: if (per_req && !(ilv && cpu_busy)) st_nxt = S_HOLD;
      S_HOLD:  if (hlda) st_nxt = S_XFER;
      S_XFER: begin
        if (!hlda)                 st_nxt = S_HOLD;
        else if (last)             st_nxt = S_IDLE;
        else if (steal)            st_nxt = S_ARMED;
        else if (ilv && cpu_busy)  st_nxt = S_ARMED;
        else                       st_nxt = S_XFER;
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_r <= '0;
      cnt_r  <= '0;
      mode_r <= M_BURST;
      done_r <= 1'b0;
    end else begin
      st     <= st_nxt;
      done_r <= 1'b0;
      if (cfg_ok) begin
        case (cfg_sel)
          SEL_ADDR: addr_r <= cfg_data;
          SEL_CNT:  cnt_r  <= cfg_data;
          SEL_MODE: mode_r <= cfg_data[1:0];
          default:  if (cfg_data[0] && cnt_r == '0) done_r <= 1'b1;
        endcase
      end
      if (mem_we) begin
        addr_r <= addr_r + W'(1);
        cnt_r  <= cnt_r - W'(1);
        if (last) done_r <= 1'b1;
      end
    end
  end

  assert_strobe_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (hold && hlda));

  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hlda) |=> hold);

  assert_ack_granted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (hold && hlda));

  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!hold && !per_ack));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we ##1 mem_we) |-> (mem_addr == W'($past(mem_addr) + W'(1))));

  assert_steal_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (steal && mem_we) |=> !hold);

  assert_burst_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!steal && !ilv && mem_we && !last) |=> hold);

  assert_ilv_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ilv && mem_we && cpu_busy) |=> !hold);

endmodule

// File: tb/tb_dma_single_chan.sv
`timescale 1ns/1ps
module tb_dma_single_chan;
  localparam int W  = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [W-1:0]  cfg_data = '0;
  logic          per_req = 1'b0;
  logic [DW-1:0] per_data = '0;
  logic          per_ack;
  logic          hold;
  logic          hlda = 1'b0;
  logic          cpu_busy = 1'b0;
  logic          mem_we;
  logic [W-1:0]  mem_addr;
  logic [DW-1:0] mem_data;
  logic          done;

  dma_single_chan #(.W(W), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .per_req(per_req), .per_data(per_data), .per_ack(per_ack), .hold(hold), .hlda(hlda),
    .cpu_busy(cpu_busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .done(done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_addr;
  int  exp_left, wr_cnt, done_cnt, hlda_lat, hcnt;
  logic [1:0] cur_mode;
  bit  mon_on = 0, req_en = 1, hold_seen = 0;
  bit  prev_we = 0, prev_hold = 0, prev_done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_burst(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  // processor model: grants after hlda_lat cycles, withdraws with hold
  always @(negedge clk) begin
    if (!hold) begin hcnt = 0; hlda <= 1'b0; end
    else begin
      if (hcnt >= hlda_lat) hlda <= 1'b1;
      hcnt++;
    end
  end

  // peripheral and processor-busy stimulus
  always @(negedge clk) begin
    per_data <= $urandom;
    cpu_busy <= ($urandom % 10) < 3;
    if (!req_en) per_req <= 1'b0;
    else if (cur_mode == 2'b01) per_req <= $urandom % 2;
    else per_req <= 1'b1;
  end

  // monitor, sampled 2 ns after the rising edge
  always begin
    @(posedge clk); #2;
    if (mon_on) begin
      if (hold && !prev_hold) begin
        hold_seen = 1;
        chk(per_req, "R1", per_req, 1);
        if (cur_mode == 2'b10) chk(!cpu_busy, "R7", cpu_busy, 0);
      end
      if (prev_we && cur_mode == 2'b01) chk(!hold, "R6", hold, 0);
      if (prev_we && is_burst(cur_mode) && exp_left > 0) chk(mem_we, "R5", mem_we, 1);
      if (prev_we && cur_mode == 2'b10 && exp_left > 0 && cpu_busy) chk(!hold, "R8", hold, 0);
      if (per_ack) chk(hold && hlda, "R1", hold && hlda, 1);
      if (mem_we) begin
        chk(hold && hlda, "R4", hold && hlda, 1);
        chk(mem_addr == exp_addr, "R2", mem_addr, exp_addr);
        chk(mem_data == per_data, "R2", mem_data, per_data);
        chk(exp_left > 0, "R3", exp_left, 1);
        exp_addr = exp_addr + 1'b1;
        exp_left--;
        wr_cnt++;
      end
      if (done) begin
        chk(exp_left == 0, "R3", exp_left, 0);
        chk(!hold && !per_ack, "R9", hold, 0);
        done_cnt++;
      end
      if (prev_done) chk(!done, "R9", done, 0);
    end
    prev_we = mem_we; prev_hold = hold; prev_done = done;
  end

  task automatic cfg(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run(input logic [1:0] md, input logic [W-1:0] a, input int n,
                     input int lat, input bit inject);
    hlda_lat = lat;
    cfg(2'd0, a); cfg(2'd1, W'(n)); cfg(2'd2, W'(md));
    exp_addr = a; exp_left = n; cur_mode = md;
    wr_cnt = 0; done_cnt = 0; hold_seen = 0;
    if (inject) req_en = 0;
    cfg(2'd3, W'(1));
    if (inject) begin
      // R11: writes while armed must all be ignored
      cfg(2'd0, 16'h7777); cfg(2'd1, W'(3)); cfg(2'd2, (md == 2'b01) ? W'(0) : W'(1));
      cfg(2'd3, W'(1));
      chk(!hold, "R11", hold, 0);
      req_en = 1;
    end
    for (int i = 0; i < 4000 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9", done_cnt, 1);
    chk(wr_cnt == n, inject ? "R11" : "R3", wr_cnt, n);
  endtask

  initial begin
    void'($urandom(32'd20240617));
    repeat (3) @(negedge clk);
    chk(!hold && !per_ack && !mem_we && !done, "R12", {hold, per_ack, mem_we, done}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);

    run(2'b00, 16'd1000, 8, 0, 0);
    run(2'b00, 16'd200, 12, 3, 0);
    run(2'b01, 16'hFFFE, 5, 1, 0);
    run(2'b10, 16'd500, 10, 2, 0);
    run(2'b11, 16'd40, 6, 1, 0);
    run(2'b00, 16'd1234, 7, 3, 1);
    run(2'b01, 16'd77, 4, 0, 1);

    // R10: zero count
    cfg(2'd1, '0);
    exp_left = 0; wr_cnt = 0; done_cnt = 0; hold_seen = 0; cur_mode = 2'b00;
    cfg(2'd3, W'(1));
    chk(done_cnt == 1, "R10", done_cnt, 1);
    repeat (4) @(negedge clk);
    chk(!hold_seen, "R10", hold_seen, 0);
    chk(done_cnt == 1 && wr_cnt == 0, "R10", wr_cnt, 0);

    for (int k = 0; k < 14; k++)
      run(2'($urandom % 4), W'($urandom), 1 + ($urandom % 40), $urandom % 4, 0);

    finish_up();
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end
endmodule